// File: doc/BRIEF.md
# Vertex output attribute mapper

This block turns the output register file of a shader unit into a vertex record with a fixed layout. Up to seven output registers are presented on the ports, each holding four 24-bit float components (x, y, z, w). An enable mask selects which registers take part. A total count limits how many of the enabled registers are used. A table of semantic slot codes says where each component goes in the record. The record holds 24 slots of 24 bits. Slots 0 to 3 hold position, 4 to 7 the quaternion, 8 to 11 the color, 12 and 13 the texture coordinate, and 14 to 16 the view vector. The remaining slots are spare.

A `start` pulse clears the record and begins a scan. The scan visits one register index per cycle, from index 0 upward. An enabled register takes the next entry of the semantic table and writes its four components into the slots named there. A register that is not enabled uses no table entry. After the scan, one more cycle replaces each color slot with its absolute value, clamped to 1.0. Then `done` pulses. The record stays on `vtx_out` until the next accepted start. The register, mask, total and table inputs must be held steady while `busy` is high.

A 24-bit float has one sign bit (bit 23), a 7-bit exponent biased by 63 and a 16-bit mantissa. The value 1.0 is encoded as 0x3F0000.

Top module: `vtx_attr_router`

## Requirements
- R1: After reset, `busy` and `done` are 0 and all 24 record slots read 0.
- R2: The k-th enabled register (k counted from 0, in ascending register index) uses semantic table entry k. The slot code for component c of entry k sits at `sem_map[(k*4+c)*5 +: 5]`. Component c of register r sits at `regs_in[(r*4+c)*24 +: 24]`. Slot s sits at `vtx_out[s*24 +: 24]`.
- R3: A register whose bit in `out_mask` is 0 writes no slot and does not advance the table entry.
- R4: Only the first `out_total` enabled registers are routed. Later enabled registers write nothing. With `out_total` = 0, nothing is routed.
- R5: A slot code of 0x1F (reserved as invalid), or any code of 24 or more, routes nothing for that component.
- R6: An accepted start clears every slot. A slot that no component reaches during the scan therefore reads 0, even if an earlier vertex wrote it.
- R7: Each color slot (8 to 11) in the finished record has its sign bit cleared.
- R8: A color slot whose magnitude is greater than 0x3F0000 reads 0x3F0000. Smaller magnitudes, and 0x3F0000 itself, pass through. Slots outside 8 to 11 are never clamped.
- R9: `done` is high for exactly one cycle per accepted start, and `busy` is low while `done` is high. A `start` that arrives while `busy` is high is ignored.
- R10: When several components write the same slot, the one written last wins. Higher register indices come later, and within a register, w comes after z, y and x.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin mapping one vertex (accepted when idle) |
| out_mask | input | 7 | Enable bit for each output register |
| out_total | input | 3 | Number of enabled registers to route |
| regs_in | input | 672 | Seven registers of four 24-bit components |
| sem_map | input | 140 | Seven table entries of four 5-bit slot codes |
| busy | output | 1 | Scan or color pass in progress |
| done | output | 1 | One-cycle pulse: record is valid |
| vtx_out | output | 576 | 24 record slots of 24 bits |

## Verification
The bench uses sparse masks to show that skipped registers do not consume a table entry. A design that indexed the table by register number would put those components in the wrong slots. Cutting the total below the number of enabled registers exposes a scan that runs on. Running a zero total right after a full vertex exposes a record that is not cleared between vertices.

The color tests use the following values:
- A negative value, which catches a missing absolute value.
- Values just above 1.0.
- 1.0 itself, which catches an off-by-one compare in the clamp.
- A large value routed to a non-color slot, which catches a clamp applied to the wrong slots.

Invalid and out-of-range codes show whether a stray write lands anyway. Collisions on one slot show whether the write order is reversed. A start pulsed mid-scan shows whether a busy block restarts.

// File: rtl/vtx_attr_router.sv
module vtx_attr_router #(
  parameter int NREG       = 7,
  parameter int FW         = 24,
  parameter int NSLOT      = 24,
  parameter int SW         = 5,
  parameter int COLOR_BASE = 8,
  parameter logic [FW-1:0] ONE_ENC = 24'h3F0000,
  localparam int CW = $clog2(NREG + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [NREG-1:0]          out_mask,
  input  logic [CW-1:0]            out_total,
  input  logic [NREG*4*FW-1:0]     regs_in,
  input  logic [NREG*4*SW-1:0]     sem_map,
  output logic                     busy,
  output logic                     done,
  output logic [NSLOT*FW-1:0]      vtx_out
);

  localparam logic [SW-1:0] INVALID = SW'((1 << SW) - 1);
  localparam int NCOL = 4;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_SAT} state_t;

  state_t          st;
  logic [CW-1:0]   ridx, oidx;
  logic [FW-1:0]   rec [NSLOT];

  logic [CW-1:0]   ridx_s, oidx_s;
  logic            scan_end;
  logic [SW-1:0]   cur_slot [4];
  logic [FW-1:0]   cur_val  [4];

  assign busy     = (st != S_IDLE);
  assign scan_end = (ridx == CW'(NREG)) || (oidx >= out_total);
  assign ridx_s   = (ridx < CW'(NREG)) ? ridx : '0;
  assign oidx_s   = (oidx < CW'(NREG)) ? oidx : '0;

  always_comb begin
    for (int c = 0; c < 4; c++) begin
      cur_slot[c] = sem_map[(int'(oidx_s) * 4 + c) * SW +: SW];
      cur_val[c]  = regs_in[(int'(ridx_s) * 4 + c) * FW +: FW];
    end
  end

  function automatic logic [FW-1:0] sat_col(input logic [FW-1:0] v);
    logic [FW-1:0] mag;
    mag = {1'b0, v[FW-2:0]};
    return (mag > ONE_ENC) ? ONE_ENC : mag;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ridx <= '0;
      oidx <= '0;
      done <= 1'b0;
      for (int s = 0; s < NSLOT; s++) rec[s] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          for (int s = 0; s < NSLOT; s++) rec[s] <= '0;
          ridx <= '0;
          oidx <= '0;
          st   <= S_SCAN;
        end
        S_SCAN: begin
          if (scan_end) begin
            st <= S_SAT;
          end else begin
            if (out_mask[ridx_s]) begin
              for (int c = 0; c < 4; c++)
                if (cur_slot[c] != INVALID && int'(cur_slot[c]) < NSLOT)
                  rec[cur_slot[c]] <= cur_val[c];
              oidx <= oidx + 1'b1;
            end
            ridx <= ridx + 1'b1;
          end
        end
        S_SAT: begin
          for (int k = 0; k < NCOL; k++)
            rec[COLOR_BASE + k] <= sat_col(rec[COLOR_BASE + k]);
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_out
      assign vtx_out[g*FW +: FW] = rec[g];
    end
  endgenerate

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(vtx_out));

  assert_oidx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (oidx <= ridx));

  generate
    for (g = 0; g < NCOL; g++) begin : g_colchk
      assert_color_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!vtx_out[(COLOR_BASE+g)*FW + FW-1]
                  && vtx_out[(COLOR_BASE+g)*FW +: FW] <= ONE_ENC));
    end
  endgenerate

endmodule

// File: tb/sim_vtx_attr_router.sv
`timescale 1ns/1ps
module sim_vtx_attr_router;
  localparam int NREG = 7, FW = 24, NSLOT = 24, SW = 5;

  logic clk = 0, rst_n = 0, start = 0;
  logic [NREG-1:0] out_mask = '0;
  logic [2:0] out_total = '0;
  logic [NREG*4*FW-1:0] regs_in = '0;
  logic [NREG*4*SW-1:0] sem_map = '0;
  logic busy, done;
  logic [NSLOT*FW-1:0] vtx_out;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [FW-1:0] m_val [NREG][4];
  logic [SW-1:0] m_sem [NREG][4];
  logic [FW-1:0] exp_rec [NSLOT];

  vtx_attr_router u0 (.clk(clk), .rst_n(rst_n), .start(start), .out_mask(out_mask),
    .out_total(out_total), .regs_in(regs_in), .sem_map(sem_map),
    .busy(busy), .done(done), .vtx_out(vtx_out));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic fill_default();
    for (int r = 0; r < NREG; r++)
      for (int c = 0; c < 4; c++) begin
        m_val[r][c] = 24'h200000 | FW'(r << 8) | FW'(c);
        m_sem[r][c] = 5'h1F;
      end
  endtask

  task automatic apply();
    for (int r = 0; r < NREG; r++)
      for (int c = 0; c < 4; c++) begin
        regs_in[(r*4+c)*FW +: FW] = m_val[r][c];
        sem_map[(r*4+c)*SW +: SW] = m_sem[r][c];
      end
  endtask

  task automatic model();
    int k;
    logic [FW-1:0] mg;
    for (int s = 0; s < NSLOT; s++) exp_rec[s] = '0;
    k = 0;
    for (int r = 0; r < NREG; r++) begin
      if (k >= int'(out_total)) break;
      if (out_mask[r]) begin
        for (int c = 0; c < 4; c++)
          if (int'(m_sem[k][c]) < NSLOT) exp_rec[m_sem[k][c]] = m_val[r][c];
        k++;
      end
    end
    for (int i = 8; i < 12; i++) begin
      mg = {1'b0, exp_rec[i][FW-2:0]};
      exp_rec[i] = (mg > 24'h3F0000) ? 24'h3F0000 : mg;
    end
  endtask

  task automatic run_vertex(input string req);
    int t;
    apply();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    t = 0;
    while (!done && t < 50) begin @(negedge clk); t++; end
    chk(done === 1'b1, {req, " done"}, 32'(done), 1);
  endtask

  task automatic compare(input string req);
    model();
    for (int s = 0; s < NSLOT; s++)
      chk(vtx_out[s*FW +: FW] === exp_rec[s], $sformatf("%s slot%0d", req, s),
          32'(vtx_out[s*FW +: FW]), 32'(exp_rec[s]));
  endtask

  task automatic t_reset();
    chk(busy === 0 && done === 0, "R1 ctrl", {30'd0, busy, done}, 0);
    chk(vtx_out === '0, "R1 record", 32'(vtx_out[31:0]), 0);
  endtask

  task automatic t_identity();
    fill_default();
    for (int e = 0; e < 6; e++) for (int c = 0; c < 4; c++) m_sem[e][c] = SW'(e*4+c);
    out_mask = 7'h7F; out_total = 7;
    run_vertex("R2");
    compare("R2 identity");
  endtask

  task automatic t_sparse();
    fill_default();
    for (int e = 0; e < 3; e++) for (int c = 0; c < 4; c++) m_sem[e][c] = SW'(e*4+c+12);
    out_mask = 7'b1010010; out_total = 3;
    run_vertex("R3");
    compare("R3 sparse");
    chk(vtx_out[12*FW +: FW] === m_val[1][0], "R2 compact entry0", 32'(vtx_out[12*FW +: FW]), 32'(m_val[1][0]));
  endtask

  task automatic t_total();
    fill_default();
    for (int e = 0; e < 6; e++) for (int c = 0; c < 4; c++) m_sem[e][c] = SW'(e*4+c);
    out_mask = 7'h7F; out_total = 2;
    run_vertex("R4");
    compare("R4 cutoff");
    out_total = 0;
    run_vertex("R4");
    chk(vtx_out === '0, "R4 R6 total zero clears", 32'(vtx_out[FW-1:0]), 0);
  endtask

  task automatic t_invalid();
    fill_default();
    m_sem[0][0] = 5'h1F; m_sem[0][1] = 5'd3; m_sem[0][2] = 5'd25; m_sem[0][3] = 5'd31;
    m_sem[1][0] = 5'd24; m_sem[1][1] = 5'h1F; m_sem[1][2] = 5'd20; m_sem[1][3] = 5'h1F;
    out_mask = 7'h03; out_total = 2;
    run_vertex("R5");
    compare("R5 invalid");
  endtask

  task automatic t_color();
    fill_default();
    m_val[0][0] = 24'hA00123; m_val[0][1] = 24'h400000;
    m_val[0][2] = 24'h3F0000; m_val[0][3] = 24'hBF0001;
    m_val[1][0] = 24'h3EFFFF; m_val[1][1] = 24'h7FFFFF;
    for (int c = 0; c < 4; c++) m_sem[0][c] = SW'(8+c);
    m_sem[1][0] = 5'd0; m_sem[1][1] = 5'd5;
    out_mask = 7'h03; out_total = 2;
    run_vertex("R7");
    compare("R7 R8 color");
    chk(vtx_out[8*FW +: FW] === 24'h200123, "R7 abs", 32'(vtx_out[8*FW +: FW]), 32'h200123);
    chk(vtx_out[10*FW +: FW] === 24'h3F0000, "R8 one passes", 32'(vtx_out[10*FW +: FW]), 32'h3F0000);
    chk(vtx_out[11*FW +: FW] === 24'h3F0000, "R8 neg clamp", 32'(vtx_out[11*FW +: FW]), 32'h3F0000);
    chk(vtx_out[5*FW +: FW] === 24'h7FFFFF, "R8 noncolor", 32'(vtx_out[5*FW +: FW]), 32'h7FFFFF);
  endtask

  task automatic t_overwrite();
    fill_default();
    m_sem[0][0] = 5'd2; m_sem[0][3] = 5'd2;
    m_sem[1][1] = 5'd2;
    m_sem[2][0] = 5'd6; m_sem[2][2] = 5'd6;
    out_mask = 7'h07; out_total = 3;
    run_vertex("R10");
    compare("R10 order");
    chk(vtx_out[2*FW +: FW] === m_val[1][1], "R10 later reg", 32'(vtx_out[2*FW +: FW]), 32'(m_val[1][1]));
    chk(vtx_out[6*FW +: FW] === m_val[2][2], "R10 later comp", 32'(vtx_out[6*FW +: FW]), 32'(m_val[2][2]));
  endtask

  task automatic t_pulse();
    int dn;
    int lvl;
    fill_default();
    for (int c = 0; c < 4; c++) m_sem[0][c] = SW'(c);
    out_mask = 7'h7F; out_total = 7;
    apply();
    dn = 0;
    lvl = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done) begin dn++; if (busy) lvl++; end
    end
    chk(dn == 1, "R9 single done", 32'(dn), 1);
    chk(lvl == 0 && busy == 0, "R9 idle", 32'(lvl), 0);
    compare("R9 record");
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    fill_default();
    apply();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_identity();
    t_sparse();
    t_total();
    t_invalid();
    t_color();
    t_overwrite();
    t_identity();
    t_pulse();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule